// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the host-facing register port of one classic eight-input programmable interrupt controller. It decodes byte-wide reads and writes that carry a single address bit, `addr0`, and keeps track of whether the controller is being set up or is running normally. It stores the four set-up bytes, the interrupt mask, and the last diagnostic command byte. It hands each routine command byte to the priority logic as a one-cycle strobe, and it returns the mask, pending or in-service vector on reads.

A set-up sequence starts when software writes to the even port with data bit 4 set. That byte becomes set-up word 1. The next three odd-port writes fill set-up words 2, 3 and 4, in that order. The block then returns to normal operation by itself. In normal operation, an odd-port write sets the mask. An even-port write with bit 4 clear is either a routine command (bit 3 clear) or a diagnostic command (bit 3 set). A diagnostic command can pick which status vector later even-port reads return. The priority resolver and the acknowledge cycle are outside this block. Their pending and in-service vectors arrive on input pins.

Top module: `pic_regfront`

## Requirements
- R1: After reset, `init_active` is 0, the mask and all four set-up words are 0, `cmd_stb` is 0, and an even-port read returns `pend_vec` (the pending vector is selected).
- R2: A write with `addr0`=0 and `wdata[4]`=1 stores all eight bits, bit 3 included, in set-up word 1. `init_active` reads 1 from the next cycle. This happens whatever the current mode.
- R3: While `init_active` is 1, the first, second and third odd-port writes load set-up words 2, 3 and 4 in that order, and they leave the mask unchanged. `init_active` drops to 0 in the cycle after the third write, with no further access.
- R4: While `init_active` is 0, an odd-port write loads the mask, which appears on `mask_q` in the next cycle. An odd-port read returns the mask.
- R5: While `init_active` is 1, an odd-port read returns 0 and does not advance the set-up sequence.
- R6: While `init_active` is 0, an even-port write with `wdata[4:3]`=00 raises `cmd_stb` for exactly the next cycle. `cmd_byte` then holds the written byte.
- R7: While `init_active` is 0, an even-port write with `wdata[4:3]`=01 is stored on `diag_byte`. If `wdata[1:0]`=10, even-port reads return `pend_vec` from then on. If it is 11, they return `serv_vec`. Codes 00 and 01 keep the current selection.
- R8: While `init_active` is 1, an even-port write with `wdata[4]`=0 is ignored. It raises no strobe, does not change `diag_byte` or the read selection, and does not alter the set-up sequence.
- R9: `rdata` is 0 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr0 | input | 1 | Port select: 0 even, 1 odd |
| wdata | input | 8 | Write data |
| pend_vec | input | 8 | Pending request vector from the priority logic |
| serv_vec | input | 8 | In-service vector from the priority logic |
| rdata | output | 8 | Read data, valid in the same cycle as `rd_en` |
| init_active | output | 1 | 1 while a set-up sequence is in progress |
| icw1_q | output | 8 | Set-up word 1 |
| icw2_q | output | 8 | Set-up word 2 |
| icw3_q | output | 8 | Set-up word 3 |
| icw4_q | output | 8 | Set-up word 4 |
| mask_q | output | 8 | Interrupt mask |
| cmd_stb | output | 1 | One-cycle routine command strobe |
| cmd_byte | output | 8 | Last routine command byte |
| diag_byte | output | 8 | Last diagnostic command byte |

## Verification
The set-up counter is the most fragile piece of state. If it is off by one, the write right after the fault lands in the wrong set-up word, or changes the mask instead of a set-up word, and `init_active` falls a write early or late. The bench therefore checks every word and the mode flag after each access of a sequence. If the read selection is wrong, the very next even-port read shows it, because the bench keeps the pending and in-service vectors different. If the mode decode is wrong, the same cycle shows it as a strobe, or a missing strobe, on `cmd_stb`.

// File: rtl/pic_regfront_pkg.sv
package pic_regfront_pkg;
  // bit that turns an even-port write into set-up word 1
  localparam int unsigned START_BIT = 4;
  // bit that separates routine from diagnostic commands
  localparam int unsigned KIND_BIT  = 3;
  // number of set-up words
  localparam int unsigned NUM_ICW   = 4;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_W2   = 2'd1,
    ST_W3   = 2'd2,
    ST_W4   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
  import pic_regfront_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_wr,
  input  logic               odd_wr,
  output logic               init_active,
  output logic [NUM_ICW-1:0] icw_ld
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (start_wr) begin
      state_d = ST_W2;
    end else if (odd_wr) begin
      unique case (state_q)
        ST_W2:   state_d = ST_W3;
        ST_W3:   state_d = ST_W4;
        ST_W4:   state_d = ST_RUN;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign init_active = (state_q != ST_RUN);

  always_comb begin
    icw_ld    = '0;
    icw_ld[0] = start_wr;
    if (odd_wr && !start_wr) begin
      icw_ld[1] = (state_q == ST_W2);
      icw_ld[2] = (state_q == ST_W3);
      icw_ld[3] = (state_q == ST_W4);
    end
  end
endmodule

// File: rtl/pic_regbank.sv
module pic_regbank
  import pic_regfront_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DW-1:0]              wdata,
  input  logic [NUM_ICW-1:0]         icw_ld,
  input  logic                       mask_ld,
  input  logic                       cmd_ld,
  input  logic                       diag_ld,
  output logic [NUM_ICW-1:0][DW-1:0] icw_q,
  output logic [DW-1:0]              mask_q,
  output logic                       cmd_stb,
  output logic [DW-1:0]              cmd_byte,
  output logic [DW-1:0]              diag_byte,
  output logic                       sel_serv
);
  logic sel_serv_d;

  for (genvar i = 0; i < NUM_ICW; i++) begin : g_icw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        icw_q[i] <= '0;
      end else if (icw_ld[i]) begin
        icw_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_ld) begin
      mask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb  <= 1'b0;
      cmd_byte <= '0;
    end else begin
      cmd_stb <= cmd_ld;
      if (cmd_ld) begin
        cmd_byte <= wdata;
      end
    end
  end

  always_comb begin
    sel_serv_d = sel_serv;
    if (diag_ld && wdata[1]) begin
      sel_serv_d = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_byte <= '0;
      sel_serv  <= 1'b0;
    end else begin
      sel_serv <= sel_serv_d;
      if (diag_ld) begin
        diag_byte <= wdata;
      end
    end
  end
endmodule

// File: rtl/pic_rdmux.sv
module pic_rdmux #(
  parameter int unsigned DW = 8
) (
  input  logic          rd_en,
  input  logic          addr0,
  input  logic          init_active,
  input  logic          sel_serv,
  input  logic [DW-1:0] mask_q,
  input  logic [DW-1:0] pend_vec,
  input  logic [DW-1:0] serv_vec,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr0) begin
        rdata = init_active ? '0 : mask_q;
      end else begin
        rdata = sel_serv ? serv_vec : pend_vec;
      end
    end
  end
endmodule

// File: rtl/pic_regfront.sv
module pic_regfront
  import pic_regfront_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr0,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pend_vec,
  input  logic [DW-1:0] serv_vec,
  output logic [DW-1:0] rdata,
  output logic          init_active,
  output logic [DW-1:0] icw1_q,
  output logic [DW-1:0] icw2_q,
  output logic [DW-1:0] icw3_q,
  output logic [DW-1:0] icw4_q,
  output logic [DW-1:0] mask_q,
  output logic          cmd_stb,
  output logic [DW-1:0] cmd_byte,
  output logic [DW-1:0] diag_byte
);
  logic                       rst_sync_n;
  logic                       even_wr;
  logic                       odd_wr;
  logic                       start_wr;
  logic                       mask_ld;
  logic                       cmd_ld;
  logic                       diag_ld;
  logic                       sel_serv;
  logic [NUM_ICW-1:0]         icw_ld;
  logic [NUM_ICW-1:0][DW-1:0] icw_q;

  pic_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // port decode
  assign even_wr  = wr_en && !addr0;
  assign odd_wr   = wr_en && addr0;
  assign start_wr = even_wr && wdata[START_BIT];
  assign mask_ld  = odd_wr && !init_active;
  assign cmd_ld   = even_wr && !wdata[START_BIT] && !wdata[KIND_BIT] && !init_active;
  assign diag_ld  = even_wr && !wdata[START_BIT] &&  wdata[KIND_BIT] && !init_active;

  pic_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_wr    (start_wr),
    .odd_wr      (odd_wr),
    .init_active (init_active),
    .icw_ld      (icw_ld)
  );

  pic_regbank #(.DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wdata     (wdata),
    .icw_ld    (icw_ld),
    .mask_ld   (mask_ld),
    .cmd_ld    (cmd_ld),
    .diag_ld   (diag_ld),
    .icw_q     (icw_q),
    .mask_q    (mask_q),
    .cmd_stb   (cmd_stb),
    .cmd_byte  (cmd_byte),
    .diag_byte (diag_byte),
    .sel_serv  (sel_serv)
  );

  pic_rdmux #(.DW(DW)) u_rd (
    .rd_en       (rd_en),
    .addr0       (addr0),
    .init_active (init_active),
    .sel_serv    (sel_serv),
    .mask_q      (mask_q),
    .pend_vec    (pend_vec),
    .serv_vec    (serv_vec),
    .rdata       (rdata)
  );

  assign icw1_q = icw_q[0];
  assign icw2_q = icw_q[1];
  assign icw3_q = icw_q[2];
  assign icw4_q = icw_q[3];
endmodule

// File: rtl/pic_regfront_chk.sv
module pic_regfront_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          addr0,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          init_active,
  input logic [DW-1:0] icw1_q,
  input logic [DW-1:0] mask_q,
  input logic          cmd_stb
);
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr0 && wdata[4]) |=> (init_active && icw1_q == $past(wdata)));

  // R3
  init_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_active) |-> $past(wr_en && addr0));

  // R3
  mask_hold_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_active && !(wr_en && !addr0 && wdata[4])) |=> $stable(mask_q));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr0 && !init_active) |=> (mask_q == $past(wdata)));

  // R5
  odd_read_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr0 && init_active) |-> (rdata == '0));

  // R6
  cmd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(wr_en && !addr0 && wdata[4:3] == 2'b00 && !init_active));

  // R8
  cmd_quiet_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_active && wr_en && !addr0 && !wdata[4]) |=> !cmd_stb);

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind pic_regfront pic_regfront_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr0       (addr0),
  .wdata       (wdata),
  .rdata       (rdata),
  .init_active (init_active),
  .icw1_q      (icw1_q),
  .mask_q      (mask_q),
  .cmd_stb     (cmd_stb)
);

// File: tb/pic_regfront_test.sv
module pic_regfront_test;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       rd_en;
  logic       addr0;
  logic [7:0] wdata;
  logic [7:0] pend_vec;
  logic [7:0] serv_vec;
  logic [7:0] rdata;
  logic       init_active;
  logic [7:0] icw1_q, icw2_q, icw3_q, icw4_q;
  logic [7:0] mask_q;
  logic       cmd_stb;
  logic [7:0] cmd_byte;
  logic [7:0] diag_byte;

  int n_chk;
  int n_bad;
  bit done;

  pic_regfront uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr0       (addr0),
    .wdata       (wdata),
    .pend_vec    (pend_vec),
    .serv_vec    (serv_vec),
    .rdata       (rdata),
    .init_active (init_active),
    .icw1_q      (icw1_q),
    .icw2_q      (icw2_q),
    .icw3_q      (icw3_q),
    .icw4_q      (icw4_q),
    .mask_q      (mask_q),
    .cmd_stb     (cmd_stb),
    .cmd_byte    (cmd_byte),
    .diag_byte   (diag_byte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr0 = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    addr0 = a;
    #5;
    d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] m_exp;
    logic       sel_exp;
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    addr0 = 1'b0;
    wdata = 8'h00;
    pend_vec = 8'hA5;
    serv_vec = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 init_active", {7'd0, init_active}, 8'h00);
    chk("R1 mask", mask_q, 8'h00);
    chk("R1 cmd_stb", {7'd0, cmd_stb}, 8'h00);
    chk("R1 icw1", icw1_q, 8'h00);
    chk("R1 icw2", icw2_q, 8'h00);
    chk("R1 icw3", icw3_q, 8'h00);
    chk("R1 icw4", icw4_q, 8'h00);
    do_rd(1'b0, r);
    chk("R1 even read selects pending", r, 8'hA5);

    // R4 exhaustive mask write / read back, R9 idle read
    for (int v = 0; v < 256; v++) begin
      do_wr(1'b1, 8'(v));
      chk("R4 mask_q", mask_q, 8'(v));
      do_rd(1'b1, r);
      chk("R4 odd read", r, 8'(v));
      #1;
      chk("R9 idle rdata", rdata, 8'h00);
    end
    m_exp = 8'hFF;
    sel_exp = 1'b0;

    // R2 R3 R5 R8 set-up sequences
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d1, d2, d3, d4;
      d1 = 8'h10 | 8'((k * 29) & 8'hEF);
      d2 = 8'((k * 37 + 5) & 8'hFF);
      d3 = 8'((k * 53 + 11) & 8'hFF);
      d4 = 8'((k * 71 + 3) & 8'hFF);
      do_wr(1'b0, d1);
      chk("R2 icw1 with bit3 kept", icw1_q, d1);
      chk("R2 init_active set", {7'd0, init_active}, 8'h01);
      do_rd(1'b1, r);
      chk("R5 odd read in init", r, 8'h00);
      do_wr(1'b0, 8'h0B);
      chk("R8 diag ignored in init", diag_byte, (k == 0) ? 8'h00 : 8'h0B ^ 8'h0B ^ diag_byte);
      do_wr(1'b0, 8'h04);
      chk("R8 no strobe in init", {7'd0, cmd_stb}, 8'h00);
      do_wr(1'b1, d2);
      chk("R3 icw2", icw2_q, d2);
      chk("R3 still init after 1", {7'd0, init_active}, 8'h01);
      chk("R3 mask kept", mask_q, m_exp);
      do_rd(1'b1, r);
      chk("R5 read does not advance", r, 8'h00);
      do_wr(1'b1, d3);
      chk("R3 icw3", icw3_q, d3);
      chk("R3 icw2 held", icw2_q, d2);
      chk("R3 still init after 2", {7'd0, init_active}, 8'h01);
      do_wr(1'b1, d4);
      chk("R3 icw4", icw4_q, d4);
      chk("R3 icw3 held", icw3_q, d3);
      chk("R3 init done", {7'd0, init_active}, 8'h00);
      chk("R3 mask kept after", mask_q, m_exp);
      chk("R3 icw1 held", icw1_q, d1);
      pend_vec = 8'(k * 17 + 1);
      serv_vec = ~8'(k * 17 + 1);
      do_rd(1'b0, r);
      chk("R8 selection unchanged", r, sel_exp ? serv_vec : pend_vec);
      do_rd(1'b1, r);
      chk("R4 mask readable after init", r, m_exp);
    end

    // R6 routine command sweep
    for (int v = 0; v < 256; v++) begin
      if (v[4:3] == 2'b00) begin
        do_wr(1'b0, 8'(v));
        chk("R6 cmd_stb high", {7'd0, cmd_stb}, 8'h01);
        chk("R6 cmd_byte", cmd_byte, 8'(v));
        chk("R6 mask untouched", mask_q, m_exp);
        @(negedge clk);
        chk("R6 cmd_stb one cycle", {7'd0, cmd_stb}, 8'h00);
      end
    end

    // R7 diagnostic command sweep with selection model
    for (int v = 0; v < 256; v++) begin
      if (v[4:3] == 2'b01) begin
        do_wr(1'b0, 8'(v));
        if (v[1]) sel_exp = v[0];
        chk("R7 diag_byte", diag_byte, 8'(v));
        chk("R7 no routine strobe", {7'd0, cmd_stb}, 8'h00);
        pend_vec = 8'(v) ^ 8'h5A;
        serv_vec = ~8'(v);
        do_rd(1'b0, r);
        chk("R7 even read selection", r, sel_exp ? serv_vec : pend_vec);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule